// File: doc/BRIEF.md
# Two-Dimensional Even-Parity Encoder and Single-Error Corrector

The block guards a data word with a grid of even-parity bits. The word is viewed as ROWS rows of COLS bits. Row `r` holds data bits `r*COLS` through `r*COLS+COLS-1`, and column `c` holds bits `c`, `COLS+c`, `2*COLS+c` and so on. The encoder side produces three things for each accepted word: one parity bit per row, one per column, and a corner bit equal to the even parity of the whole word.

The decoder side takes a received word together with its received row, column and corner bits and recomputes all three. It compares them to form a row mismatch vector, a column mismatch vector and a corner mismatch bit. A lone flipped data bit shows up as exactly one row mismatch, one column mismatch and a corner mismatch. The bit where that row and column cross is inverted. A lone flipped check bit is recognised and reported as corrected, and the data passes through untouched. Every other non-zero mismatch pattern is reported as uncorrectable, and the data passes through untouched.

Each side has a single input strobe and a single output strobe, and there is no back-pressure. Every strobed input produces a registered result one clock later, and that result is shown for exactly one cycle. The consumer must take a result in the cycle its strobe is high. Outputs hold their last value while the strobe is low.

Top module: `grid_parity_codec`

## Requirements
- R1: One cycle after `enc_valid_i`, `enc_row_par_o[r]` is the XOR of data bits `r*COLS` to `r*COLS+COLS-1`.
- R2: One cycle after `enc_valid_i`, `enc_col_par_o[c]` is the XOR of data bits `c + k*COLS` for every row k.
- R3: `enc_corner_o` is the XOR of all data bits. It therefore equals the XOR of the row parity outputs and also the XOR of the column parity outputs.
- R4: `enc_valid_o` and `dec_valid_o` are high in exactly the cycle after their input strobe was high. They are low in every other cycle.
- R5: A received codeword with no mismatch gives `err_detected_o`=0, `corrected_o`=0 and `uncorrectable_o`=0, and `dec_data_o` equals the received data.
- R6: A codeword with exactly one data bit flipped gives the original data on `dec_data_o`, with `err_detected_o`=1, `corrected_o`=1 and `uncorrectable_o`=0.
- R7: A codeword with exactly one row, column or corner check bit flipped gives `err_detected_o`=1, `corrected_o`=1 and `uncorrectable_o`=0, and `dec_data_o` equals the received data.
- R8: A codeword with any two bits flipped (data or check, in any combination) gives `err_detected_o`=1, `corrected_o`=0 and `uncorrectable_o`=1, and `dec_data_o` equals the received data.
- R9: `corrected_o` and `uncorrectable_o` are never both 1. Whenever either is 1, `err_detected_o` is 1, and `err_detected_o`=1 implies one of them is 1.
- R10: While synchronous active-high `rst` is sampled high, both output strobes and all three flags are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Encoder input strobe |
| enc_data_i | input | ROWS*COLS | Word to encode |
| enc_valid_o | output | 1 | Encoder result strobe |
| enc_row_par_o | output | ROWS | Row parity bits |
| enc_col_par_o | output | COLS | Column parity bits |
| enc_corner_o | output | 1 | Corner parity bit |
| dec_valid_i | input | 1 | Decoder input strobe |
| dec_data_i | input | ROWS*COLS | Received word |
| dec_row_par_i | input | ROWS | Received row parity bits |
| dec_col_par_i | input | COLS | Received column parity bits |
| dec_corner_i | input | 1 | Received corner bit |
| dec_valid_o | output | 1 | Decoder result strobe |
| dec_data_o | output | ROWS*COLS | Corrected or passed-through word |
| err_detected_o | output | 1 | Some mismatch was found |
| corrected_o | output | 1 | A single-bit error was repaired or recognised |
| uncorrectable_o | output | 1 | Mismatch pattern cannot be repaired |

## Verification
The hardest patterns to reach are the two-bit errors whose syndrome resembles a single error. Examples are a data bit plus the corner bit, which leaves one row and one column mismatch but no corner mismatch, and a data bit plus its own row check bit, which leaves only a column and the corner mismatched. Random words almost never produce these. The bench therefore builds each received codeword from a clean encoding and applies explicit flip masks. The masks cover every single data position, every check bit, and each class of double flip that pairs data with row, column or corner bits.

// File: rtl/grid_parity_pkg.sv
package grid_parity_pkg;

  // Outcome of one decode, derived from the mismatch pattern.
  typedef enum logic [1:0] {
    SYN_CLEAN     = 2'd0,
    SYN_FIX_DATA  = 2'd1,
    SYN_FIX_CHECK = 2'd2,
    SYN_MULTI     = 2'd3
  } syn_class_e;

  // Saturating population count of a mismatch vector.
  typedef enum logic [1:0] {
    CNT_NONE = 2'd0,
    CNT_ONE  = 2'd1,
    CNT_MANY = 2'd2
  } hit_count_e;

  function automatic syn_class_e classify(input hit_count_e rows,
                                          input hit_count_e cols,
                                          input logic corner_hit);
    syn_class_e res;
    if (rows == CNT_NONE && cols == CNT_NONE)
      res = corner_hit ? SYN_FIX_CHECK : SYN_CLEAN;
    else if (rows == CNT_ONE && cols == CNT_ONE && corner_hit)
      res = SYN_FIX_DATA;
    else if (!corner_hit &&
             ((rows == CNT_ONE && cols == CNT_NONE) ||
              (rows == CNT_NONE && cols == CNT_ONE)))
      res = SYN_FIX_CHECK;
    else
      res = SYN_MULTI;
    return res;
  endfunction

endpackage

// File: rtl/grid_parity_gen.sv
module grid_parity_gen #(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  localparam int W = ROWS * COLS
) (
  input  logic [W-1:0]    data,
  output logic [ROWS-1:0] row_par,
  output logic [COLS-1:0] col_par,
  output logic            corner
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_par[r] = ^data[r*COLS +: COLS];
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] column_bits;
    for (genvar k = 0; k < ROWS; k++) begin : g_pick
      assign column_bits[k] = data[k*COLS + c];
    end
    assign col_par[c] = ^column_bits;
  end

  assign corner = ^data;

endmodule

// File: rtl/grid_hit_counter.sv
module grid_hit_counter
  import grid_parity_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] hits,
  output hit_count_e   cnt
);

  always_comb begin
    cnt = CNT_NONE;
    for (int i = 0; i < N; i++) begin
      if (hits[i]) cnt = (cnt == CNT_NONE) ? CNT_ONE : CNT_MANY;
    end
  end

endmodule

// File: rtl/grid_syndrome.sv
module grid_syndrome
  import grid_parity_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  localparam int W = ROWS * COLS
) (
  input  logic [W-1:0]    rx_data,
  input  logic [ROWS-1:0] rx_row_par,
  input  logic [COLS-1:0] rx_col_par,
  input  logic            rx_corner,
  output logic [ROWS-1:0] row_hit,
  output logic [COLS-1:0] col_hit,
  output syn_class_e      cls
);

  logic [ROWS-1:0] calc_row;
  logic [COLS-1:0] calc_col;
  logic            calc_corner;
  logic            corner_hit;
  hit_count_e      row_cnt;
  hit_count_e      col_cnt;

  grid_parity_gen #(.ROWS(ROWS), .COLS(COLS)) u_recalc (
    .data    (rx_data),
    .row_par (calc_row),
    .col_par (calc_col),
    .corner  (calc_corner)
  );

  assign row_hit    = calc_row ^ rx_row_par;
  assign col_hit    = calc_col ^ rx_col_par;
  assign corner_hit = calc_corner ^ rx_corner;

  grid_hit_counter #(.N(ROWS)) u_row_cnt (.hits(row_hit), .cnt(row_cnt));
  grid_hit_counter #(.N(COLS)) u_col_cnt (.hits(col_hit), .cnt(col_cnt));

  assign cls = classify(row_cnt, col_cnt, corner_hit);

endmodule

// File: rtl/grid_bit_fixer.sv
module grid_bit_fixer #(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  localparam int W = ROWS * COLS
) (
  input  logic [W-1:0]    data_i,
  input  logic [ROWS-1:0] row_hit,
  input  logic [COLS-1:0] col_hit,
  input  logic            enable,
  output logic [W-1:0]    data_o
);

  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      assign data_o[r*COLS + c] =
        data_i[r*COLS + c] ^ (enable & row_hit[r] & col_hit[c]);
    end
  end

endmodule

// File: rtl/grid_parity_codec.sv
module grid_parity_codec
  import grid_parity_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  localparam int W = ROWS * COLS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enc_valid_i,
  input  logic [W-1:0]    enc_data_i,
  output logic            enc_valid_o,
  output logic [ROWS-1:0] enc_row_par_o,
  output logic [COLS-1:0] enc_col_par_o,
  output logic            enc_corner_o,
  input  logic            dec_valid_i,
  input  logic [W-1:0]    dec_data_i,
  input  logic [ROWS-1:0] dec_row_par_i,
  input  logic [COLS-1:0] dec_col_par_i,
  input  logic            dec_corner_i,
  output logic            dec_valid_o,
  output logic [W-1:0]    dec_data_o,
  output logic            err_detected_o,
  output logic            corrected_o,
  output logic            uncorrectable_o
);

  // ---------------- encoder ----------------
  logic [ROWS-1:0] enc_row_c;
  logic [COLS-1:0] enc_col_c;
  logic            enc_corner_c;

  grid_parity_gen #(.ROWS(ROWS), .COLS(COLS)) u_enc (
    .data    (enc_data_i),
    .row_par (enc_row_c),
    .col_par (enc_col_c),
    .corner  (enc_corner_c)
  );

  always_ff @(posedge clk) begin
    if (rst) enc_valid_o <= 1'b0;
    else     enc_valid_o <= enc_valid_i;
  end

  always_ff @(posedge clk) begin
    if (enc_valid_i) begin
      enc_row_par_o <= enc_row_c;
      enc_col_par_o <= enc_col_c;
      enc_corner_o  <= enc_corner_c;
    end
  end

  // The separately built corner must agree with both parity vectors.
  p_corner_agrees_r3: assert property (@(posedge clk) disable iff (rst)
    enc_valid_o |-> ((^enc_row_par_o) == enc_corner_o) &&
                    ((^enc_col_par_o) == enc_corner_o));

  p_enc_latency_r4: assert property (@(posedge clk) disable iff (rst)
    enc_valid_i |=> enc_valid_o);

  p_enc_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !enc_valid_i |=> !enc_valid_o);

  // ---------------- decoder ----------------
  logic [ROWS-1:0] row_hit;
  logic [COLS-1:0] col_hit;
  syn_class_e      cls;
  logic [W-1:0]    fixed_data;

  grid_syndrome #(.ROWS(ROWS), .COLS(COLS)) u_syn (
    .rx_data    (dec_data_i),
    .rx_row_par (dec_row_par_i),
    .rx_col_par (dec_col_par_i),
    .rx_corner  (dec_corner_i),
    .row_hit    (row_hit),
    .col_hit    (col_hit),
    .cls        (cls)
  );

  grid_bit_fixer #(.ROWS(ROWS), .COLS(COLS)) u_fix (
    .data_i  (dec_data_i),
    .row_hit (row_hit),
    .col_hit (col_hit),
    .enable  (cls == SYN_FIX_DATA),
    .data_o  (fixed_data)
  );

  // A data repair inverts exactly one bit of the received word.
  p_one_bit_repair_r6: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_i && cls == SYN_FIX_DATA) |->
      ($countones(fixed_data ^ dec_data_i) == 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid_o     <= 1'b0;
      err_detected_o  <= 1'b0;
      corrected_o     <= 1'b0;
      uncorrectable_o <= 1'b0;
    end else begin
      dec_valid_o <= dec_valid_i;
      if (dec_valid_i) begin
        err_detected_o  <= (cls != SYN_CLEAN);
        corrected_o     <= (cls == SYN_FIX_DATA) || (cls == SYN_FIX_CHECK);
        uncorrectable_o <= (cls == SYN_MULTI);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dec_valid_i) dec_data_o <= fixed_data;
  end

  p_dec_latency_r4: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i |=> dec_valid_o);

  p_dec_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_i |=> !dec_valid_o);

  p_multi_passthru_r8: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_i && cls == SYN_MULTI) |=>
      (dec_data_o == $past(dec_data_i)) && uncorrectable_o && !corrected_o);

  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(corrected_o && uncorrectable_o));

  p_flags_imply_err_r9: assert property (@(posedge clk) disable iff (rst)
    err_detected_o == (corrected_o || uncorrectable_o));

  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> !enc_valid_o && !dec_valid_o && !err_detected_o &&
            !corrected_o && !uncorrectable_o);

endmodule

// File: tb/grid_parity_codec_tb_top.sv
module grid_parity_codec_tb_top;

  localparam int R = 4;
  localparam int C = 8;
  localparam int W = R * C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk; // 50 MHz

  logic         enc_valid_i = 1'b0;
  logic [W-1:0] enc_data_i = '0;
  logic         enc_valid_o;
  logic [R-1:0] enc_row_par_o;
  logic [C-1:0] enc_col_par_o;
  logic         enc_corner_o;
  logic         dec_valid_i = 1'b0;
  logic [W-1:0] dec_data_i = '0;
  logic [R-1:0] dec_row_par_i = '0;
  logic [C-1:0] dec_col_par_i = '0;
  logic         dec_corner_i = 1'b0;
  logic         dec_valid_o;
  logic [W-1:0] dec_data_o;
  logic         err_detected_o;
  logic         corrected_o;
  logic         uncorrectable_o;

  grid_parity_codec #(.ROWS(R), .COLS(C)) dut_i (
    .clk(clk), .rst(rst),
    .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
    .enc_valid_o(enc_valid_o), .enc_row_par_o(enc_row_par_o),
    .enc_col_par_o(enc_col_par_o), .enc_corner_o(enc_corner_o),
    .dec_valid_i(dec_valid_i), .dec_data_i(dec_data_i),
    .dec_row_par_i(dec_row_par_i), .dec_col_par_i(dec_col_par_i),
    .dec_corner_i(dec_corner_i),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
    .err_detected_o(err_detected_o), .corrected_o(corrected_o),
    .uncorrectable_o(uncorrectable_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [R-1:0] rows;
    logic [C-1:0] cols;
    logic         corner;
    int           sent;
  } enc_item_t;

  typedef struct {
    logic [W-1:0] data;
    logic         err;
    logic         cor;
    logic         unc;
    int           sent;
    string        tag;
  } dec_item_t;

  enc_item_t enc_q[$];
  dec_item_t dec_q[$];

  // ---------- reference parity from the requirements ----------
  function automatic logic [R-1:0] ref_rows(input logic [W-1:0] d);
    logic [R-1:0] p = '0;
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) p[r] ^= d[r*C + c];
    return p;
  endfunction

  function automatic logic [C-1:0] ref_cols(input logic [W-1:0] d);
    logic [C-1:0] p = '0;
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) p[c] ^= d[r*C + c];
    return p;
  endfunction

  function automatic logic ref_corner(input logic [W-1:0] d);
    logic p = 1'b0;
    for (int i = 0; i < W; i++) p ^= d[i];
    return p;
  endfunction

  task automatic check(input bit ok, input string what, input string act,
                       input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", what, act, exp);
    end
  endtask

  // ---------- drivers ----------
  task automatic send_enc(input logic [W-1:0] d);
    enc_item_t it;
    @(negedge clk);
    enc_valid_i = 1'b1;
    enc_data_i  = d;
    it.rows   = ref_rows(d);
    it.cols   = ref_cols(d);
    it.corner = ref_corner(d);
    it.sent   = cyc;
    enc_q.push_back(it);
  endtask

  // kind: 0 clean, 1 single (corrected), 2 double (uncorrectable)
  task automatic send_dec(input logic [W-1:0] d, input logic [W-1:0] dflip,
                          input logic [R-1:0] rflip, input logic [C-1:0] cflip,
                          input logic kflip, input int kind, input string tag);
    dec_item_t it;
    logic [W-1:0] rx;
    rx = d ^ dflip;
    @(negedge clk);
    dec_valid_i   = 1'b1;
    dec_data_i    = rx;
    dec_row_par_i = ref_rows(d) ^ rflip;
    dec_col_par_i = ref_cols(d) ^ cflip;
    dec_corner_i  = ref_corner(d) ^ kflip;
    it.data = (kind == 1) ? d : rx;
    it.err  = (kind != 0);
    it.cor  = (kind == 1);
    it.unc  = (kind == 2);
    it.sent = cyc;
    it.tag  = tag;
    dec_q.push_back(it);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    enc_valid_i = 1'b0;
    dec_valid_i = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // ---------- monitor / scoreboard ----------
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (enc_valid_o) begin
        if (enc_q.size() == 0) begin
          check(1'b0, "R4 encoder strobe with nothing pending", "1", "0");
        end else begin
          enc_item_t e;
          e = enc_q.pop_front();
          check(cyc == e.sent + 1, "R4 encoder latency",
                $sformatf("%0d", cyc - e.sent), "1");
          check(enc_row_par_o == e.rows, "R1 row parity",
                $sformatf("%h", enc_row_par_o), $sformatf("%h", e.rows));
          check(enc_col_par_o == e.cols, "R2 column parity",
                $sformatf("%h", enc_col_par_o), $sformatf("%h", e.cols));
          check(enc_corner_o == e.corner, "R3 corner parity",
                $sformatf("%b", enc_corner_o), $sformatf("%b", e.corner));
        end
      end
      if (dec_valid_o) begin
        if (dec_q.size() == 0) begin
          check(1'b0, "R4 decoder strobe with nothing pending", "1", "0");
        end else begin
          dec_item_t x;
          x = dec_q.pop_front();
          check(cyc == x.sent + 1, {x.tag, " R4 decoder latency"},
                $sformatf("%0d", cyc - x.sent), "1");
          check(dec_data_o == x.data, {x.tag, " data"},
                $sformatf("%h", dec_data_o), $sformatf("%h", x.data));
          check({err_detected_o, corrected_o, uncorrectable_o} ==
                {x.err, x.cor, x.unc}, {x.tag, " flags err/cor/unc"},
                $sformatf("%b%b%b", err_detected_o, corrected_o, uncorrectable_o),
                $sformatf("%b%b%b", x.err, x.cor, x.unc));
          check(!(corrected_o && uncorrectable_o) &&
                (err_detected_o == (corrected_o || uncorrectable_o)),
                "R9 flag consistency",
                $sformatf("%b%b%b", err_detected_o, corrected_o, uncorrectable_o),
                "consistent");
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // ---------- watchdog ----------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  // ---------- stimulus ----------
  logic [W-1:0] base;

  initial begin
    // R10: strobes held high during reset must not show at the outputs.
    enc_valid_i = 1'b1;
    dec_valid_i = 1'b1;
    repeat (3) @(negedge clk);
    check(!enc_valid_o && !dec_valid_o && !err_detected_o && !corrected_o &&
          !uncorrectable_o, "R10 outputs under reset",
          $sformatf("%b%b%b%b%b", enc_valid_o, dec_valid_o, err_detected_o,
                    corrected_o, uncorrectable_o), "00000");
    enc_valid_i = 1'b0;
    dec_valid_i = 1'b0;
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 R2 R3: encoder over distinct patterns, back to back then gapped.
    send_enc('0);
    send_enc('1);
    send_enc(32'hA5A5_0F0F);
    send_enc(32'h0000_0001);
    send_enc(32'h8000_0000);
    for (int i = 0; i < 8; i++) send_enc($urandom);
    idle(3);
    send_enc(32'h1234_5678);
    idle(2);
    send_enc(32'hFFFF_0000);
    idle(3);

    // R5: clean codewords.
    send_dec('0, '0, '0, '0, 1'b0, 0, "R5 clean zero");
    send_dec('1, '0, '0, '0, 1'b0, 0, "R5 clean ones");
    for (int i = 0; i < 4; i++) send_dec($urandom, '0, '0, '0, 1'b0, 0, "R5 clean random");
    idle(2);

    // R6: every single data position flipped.
    base = 32'h5EC3_9A71;
    for (int b = 0; b < W; b++)
      send_dec(base, W'(1) << b, '0, '0, 1'b0, 1, $sformatf("R6 data bit %0d", b));
    send_dec('0, W'(1) << (W - 1), '0, '0, 1'b0, 1, "R6 top bit of zero word");
    idle(2);

    // R7: each check bit flipped alone.
    for (int r = 0; r < R; r++)
      send_dec(base, '0, R'(1) << r, '0, 1'b0, 1, $sformatf("R7 row check %0d", r));
    for (int c = 0; c < C; c++)
      send_dec(base, '0, '0, C'(1) << c, 1'b0, 1, $sformatf("R7 column check %0d", c));
    send_dec(base, '0, '0, '0, 1'b1, 1, "R7 corner check");
    idle(2);

    // R8: double flips of every kind of pair.
    send_dec(base, W'(32'h3), '0, '0, 1'b0, 2, "R8 two data same row");
    send_dec(base, (W'(1) << 2) | (W'(1) << (C + 2)), '0, '0, 1'b0, 2,
             "R8 two data same column");
    send_dec(base, (W'(1) << 3) | (W'(1) << (2*C + 5)), '0, '0, 1'b0, 2,
             "R8 two data distinct row and column");
    send_dec(base, W'(1) << (C + 4), R'(2), '0, 1'b0, 2, "R8 data plus own row check");
    send_dec(base, W'(1) << (C + 4), R'(8), '0, 1'b0, 2, "R8 data plus other row check");
    send_dec(base, W'(1) << (C + 4), '0, C'(1) << 4, 1'b0, 2, "R8 data plus own column check");
    send_dec(base, W'(1) << 9, '0, '0, 1'b1, 2, "R8 data plus corner");
    send_dec(base, '0, R'(1), C'(1), 1'b0, 2, "R8 row check plus column check");
    send_dec(base, '0, R'(5), '0, 1'b0, 2, "R8 two row checks");
    send_dec(base, '0, '0, C'(8'h81), 1'b0, 2, "R8 two column checks");
    send_dec(base, '0, R'(4), '0, 1'b1, 2, "R8 row check plus corner");
    send_dec(base, '0, '0, C'(8'h10), 1'b1, 2, "R8 column check plus corner");
    send_dec('1, W'(1) << (W - 1), '0, '0, 1'b1, 2, "R8 corner plus last data bit");
    idle(4);

    check(enc_q.size() == 0 && dec_q.size() == 0, "R4 every strobe answered",
          $sformatf("%0d/%0d", enc_q.size(), dec_q.size()), "0/0");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule